// File: doc/BRIEF.md
# Block-parallel decision-feedback interference canceller

This block refines the hard bit decisions of a K-user synchronous BPSK spread-spectrum uplink by multistage parallel interference cancellation. Per symbol vector it is given the complex despread outputs of every user's matched filter and a complex user cross-correlation matrix. Stage by stage, it subtracts from each user's matched-filter output the interference predicted from the other users' current bit estimates. Its result is the soft cancelled values and hard decisions of one stage, chosen per vector.

Users are grouped into K/B blocks of B consecutive users. All users of a block are computed in parallel. Blocks are handled in index order inside a stage. Interference from users of earlier blocks is cancelled with the decisions already made in the current stage. Interference from the user's own block and from later blocks is cancelled with the previous stage's decisions. With B=1 the engine is a fully serial decision-feedback canceller. With B=K it is a plain parallel canceller with no dependency inside a stage. Each block step takes two cycles. In the first, the terms whose decisions are already settled (own block and later blocks) are accumulated. In the second, the terms of earlier blocks are subtracted and the block's decisions are written back.

Top module: `bpdf_canceller`

## Requirements
- R1: After reset, in_ready_o is 1, done_o is 0, and bits_o and both soft outputs are all zero.
- R2: With stage 0 selected, the soft outputs equal the captured matched-filter inputs and each decision is the sign of the real input: bit 1 for a negative real part, bit 0 otherwise.
- R3: A stage output for user k is z = sat(y[k] − Σ_{j≠k} R[k][j]·d[j]) on real and imaginary parts separately. d[j] is +1 for decision bit 0 and −1 for bit 1. The diagonal entry R[k][k] has no effect. Entry R[k][j] sits at bit offset (k·K+j)·W of r_re_i and r_im_i, and user k's values sit at offset k·W. The decision bit is the sign bit of the saturated real part.
- R4: Within a stage, d[j] for j in an earlier block than k is that stage's new decision. For j in the same or a later block, d[j] is the previous stage's decision (stage 0 being R2's decisions).
- R5: With B=1 the result equals one-user-at-a-time decision feedback. With B=K it equals fully parallel cancellation, in which every user uses only previous-stage decisions.
- R6: Real and imaginary soft values saturate to the range −32768..32767 when W=16, with no wrap-around.
- R7: A real part exactly zero, before or after cancellation, gives decision bit 0 (+1), whatever the imaginary part.
- R8: done_o is a one-cycle pulse exactly 1 + 2·S·(K/B) cycles after the accepting edge, where S is the selected stage. Outputs are final in that cycle and hold until the next vector is accepted.
- R9: A vector is accepted on an edge with in_valid_i and in_ready_o both high. in_ready_o is 0 from the cycle after acceptance until done_o. in_valid_i and the data inputs have no effect while in_ready_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid_i | input | 1 | Symbol vector offered |
| in_ready_o | output | 1 | Engine idle, a vector can be accepted |
| stage_sel_i | input | clog2(M+1) | Stage to return, 0..M (larger values act as M) |
| y_re_i | input | K·W | Real matched-filter outputs, user k at k·W |
| y_im_i | input | K·W | Imaginary matched-filter outputs |
| r_re_i | input | K·K·W | Real correlation entries, R[k][j] at (k·K+j)·W |
| r_im_i | input | K·K·W | Imaginary correlation entries |
| done_o | output | 1 | One-cycle pulse: selected stage complete |
| bits_o | output | K | Hard decisions, 1 = −1 and 0 = +1 |
| soft_re_o | output | K·W | Real soft cancelled values |
| soft_im_o | output | K·W | Imaginary soft cancelled values |

## Verification
Three copies of the engine, with block sizes 2, 1 and K, share each stimulus. Every stage from 0 to M is requested, and each copy is compared with its own arithmetic model. Zero cross-correlation shows that the decisions pass through unchanged. Moderate random matrices with nonzero diagonals separate the serial, block and fully parallel feedback orderings, and would expose any self-cancellation. Full-scale random values force saturation. Vectors with zero real parts and isolated rows pin the tie decision. Data offered while the engine is busy checks that a running vector is undisturbed.

// File: rtl/bpdf_pkg.sv
package bpdf_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_INIT = 2'd1,
    ST_PRIM = 2'd2,
    ST_SEC  = 2'd3
  } bpdf_state_e;

  // Width of a counter holding 0..n-1, never below one bit.
  function automatic int safe_w(input int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/bpdf_term_sum.sv
// Sum of sign-flipped correlation entries for one user row, masked per term.
module bpdf_term_sum #(
  parameter int K  = 10,
  parameter int W  = 16,
  parameter int AW = 21
) (
  input  logic [K*W-1:0]      row_re_i,
  input  logic [K*W-1:0]      row_im_i,
  input  logic [K-1:0]        dec_i,
  input  logic [K-1:0]        mask_i,
  output logic signed [AW-1:0] sum_re_o,
  output logic signed [AW-1:0] sum_im_o
);
  logic signed [AW-1:0] tr;
  logic signed [AW-1:0] ti;

  always_comb begin
    sum_re_o = '0;
    sum_im_o = '0;
    tr = '0;
    ti = '0;
    for (int j = 0; j < K; j++) begin
      tr = AW'($signed(row_re_i[j*W +: W]));
      ti = AW'($signed(row_im_i[j*W +: W]));
      // a decision of -1 flips the entry instead of multiplying
      if (dec_i[j]) begin
        tr = -tr;
        ti = -ti;
      end
      if (mask_i[j]) begin
        sum_re_o = sum_re_o + tr;
        sum_im_o = sum_im_o + ti;
      end
    end
  end
endmodule

// File: rtl/bpdf_lane.sv
// One parallel user lane: primary accumulate, then secondary subtract and saturate.
module bpdf_lane
  import bpdf_pkg::*;
#(
  parameter int K = 10,
  parameter int W = 16,
  localparam int AW = W + safe_w(K) + 1,
  localparam int ZW = AW + 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           prim_i,
  input  logic [K*W-1:0] row_re_i,
  input  logic [K*W-1:0] row_im_i,
  input  logic [K-1:0]   dec_i,
  input  logic [K-1:0]   pmask_i,
  input  logic [K-1:0]   smask_i,
  input  logic [W-1:0]   y_re_i,
  input  logic [W-1:0]   y_im_i,
  output logic [W-1:0]   z_re_o,
  output logic [W-1:0]   z_im_o,
  output logic           z_bit_o
);
  localparam logic signed [ZW-1:0] POS_LIM = $signed({{(ZW-W+1){1'b0}}, {(W-1){1'b1}}});
  localparam logic signed [ZW-1:0] NEG_LIM = $signed({{(ZW-W+1){1'b1}}, {(W-1){1'b0}}});
  localparam logic [W-1:0] POS_W = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] NEG_W = {1'b1, {(W-1){1'b0}}};

  logic [K-1:0]          mask;
  logic signed [AW-1:0]  sum_re, sum_im;
  logic signed [AW-1:0]  acc_re, acc_im;
  logic signed [ZW-1:0]  wide_re, wide_im;

  // one shared adder tree: primary terms first, secondary terms next
  assign mask = prim_i ? pmask_i : smask_i;

  bpdf_term_sum #(.K(K), .W(W), .AW(AW)) u_sum (
    .row_re_i (row_re_i),
    .row_im_i (row_im_i),
    .dec_i    (dec_i),
    .mask_i   (mask),
    .sum_re_o (sum_re),
    .sum_im_o (sum_im)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_re <= '0;
      acc_im <= '0;
    end else if (prim_i) begin
      acc_re <= sum_re;
      acc_im <= sum_im;
    end
  end

  assign wide_re = ZW'($signed(y_re_i)) - ZW'(acc_re) - ZW'(sum_re);
  assign wide_im = ZW'($signed(y_im_i)) - ZW'(acc_im) - ZW'(sum_im);

  always_comb begin
    if (wide_re > POS_LIM)      z_re_o = POS_W;
    else if (wide_re < NEG_LIM) z_re_o = NEG_W;
    else                        z_re_o = wide_re[W-1:0];
    if (wide_im > POS_LIM)      z_im_o = POS_W;
    else if (wide_im < NEG_LIM) z_im_o = NEG_W;
    else                        z_im_o = wide_im[W-1:0];
  end

  // saturation keeps the sign, so a zero real part decides +1 (bit 0)
  assign z_bit_o = z_re_o[W-1];
endmodule

// File: rtl/bpdf_ctrl.sv
// Sequencer: capture, stage-0 init, then per block a primary and a secondary cycle.
module bpdf_ctrl
  import bpdf_pkg::*;
#(
  parameter int NB = 5,
  parameter int M  = 4,
  localparam int SW = safe_w(M + 1),
  localparam int BW = safe_w(NB)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic [SW-1:0] sel_i,
  output logic          ready_o,
  output logic          init_o,
  output logic          prim_o,
  output logic          sec_o,
  output logic [BW-1:0] blk_o,
  output logic          done_o
);
  bpdf_state_e   state;
  logic [BW-1:0] blk;
  logic [SW-1:0] stage;
  logic [SW-1:0] sel_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      blk    <= '0;
      stage  <= '0;
      sel_q  <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start_i) begin
            sel_q <= (int'(sel_i) > M) ? SW'(M) : sel_i;
            state <= ST_INIT;
          end
        end
        ST_INIT: begin
          blk   <= '0;
          stage <= SW'(1);
          if (sel_q == '0) begin
            done_o <= 1'b1;
            state  <= ST_IDLE;
          end else begin
            state <= ST_PRIM;
          end
        end
        ST_PRIM: state <= ST_SEC;
        ST_SEC: begin
          if (blk == BW'(NB - 1)) begin
            blk <= '0;
            if (stage == sel_q) begin
              done_o <= 1'b1;
              state  <= ST_IDLE;
            end else begin
              stage <= stage + SW'(1);
              state <= ST_PRIM;
            end
          end else begin
            blk   <= blk + BW'(1);
            state <= ST_PRIM;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign ready_o = (state == ST_IDLE);
  assign init_o  = (state == ST_INIT);
  assign prim_o  = (state == ST_PRIM);
  assign sec_o   = (state == ST_SEC);
  assign blk_o   = blk;
endmodule

// File: rtl/bpdf_canceller.sv
module bpdf_canceller
  import bpdf_pkg::*;
#(
  parameter int K = 10,
  parameter int M = 4,
  parameter int B = 2,
  parameter int W = 16,
  localparam int NB = K / B,
  localparam int SW = safe_w(M + 1),
  localparam int BW = safe_w(NB)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid_i,
  output logic            in_ready_o,
  input  logic [SW-1:0]   stage_sel_i,
  input  logic [K*W-1:0]  y_re_i,
  input  logic [K*W-1:0]  y_im_i,
  input  logic [K*K*W-1:0] r_re_i,
  input  logic [K*K*W-1:0] r_im_i,
  output logic            done_o,
  output logic [K-1:0]    bits_o,
  output logic [K*W-1:0]  soft_re_o,
  output logic [K*W-1:0]  soft_im_o
);
  logic            ready, start, init, prim, sec;
  logic [BW-1:0]   blk;
  logic [K*W-1:0]  y_re_q, y_im_q;
  logic [K*K*W-1:0] r_re_q, r_im_q;
  logic [K-1:0]    bits_q;
  logic [K*W-1:0]  soft_re_q, soft_im_q;
  logic [B-1:0]    lane_bit;
  logic [B*W-1:0]  lane_re, lane_im;

  assign start = in_valid_i & ready;

  bpdf_ctrl #(.NB(NB), .M(M)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .start_i (start),
    .sel_i   (stage_sel_i),
    .ready_o (ready),
    .init_o  (init),
    .prim_o  (prim),
    .sec_o   (sec),
    .blk_o   (blk),
    .done_o  (done_o)
  );

  for (genvar l = 0; l < B; l++) begin : g_lane
    logic [K*W-1:0] row_re, row_im;
    logic [W-1:0]   ly_re, ly_im;
    logic [K-1:0]   pmask, smask;

    // pick this lane's user from the active block
    always_comb begin
      row_re = '0;
      row_im = '0;
      ly_re  = '0;
      ly_im  = '0;
      for (int b = 0; b < NB; b++) begin
        if (blk == BW'(b)) begin
          row_re = r_re_q[(b*B+l)*K*W +: K*W];
          row_im = r_im_q[(b*B+l)*K*W +: K*W];
          ly_re  = y_re_q[(b*B+l)*W +: W];
          ly_im  = y_im_q[(b*B+l)*W +: W];
        end
      end
    end

    // primary: own block and later blocks, self excluded; secondary: earlier blocks
    always_comb begin
      for (int j = 0; j < K; j++) begin
        pmask[j] = (BW'(j / B) >= blk) && !((BW'(j / B) == blk) && ((j % B) == l));
        smask[j] = (BW'(j / B) < blk);
      end
    end

    bpdf_lane #(.K(K), .W(W)) u_lane (
      .clk      (clk),
      .rst      (rst),
      .prim_i   (prim),
      .row_re_i (row_re),
      .row_im_i (row_im),
      .dec_i    (bits_q),
      .pmask_i  (pmask),
      .smask_i  (smask),
      .y_re_i   (ly_re),
      .y_im_i   (ly_im),
      .z_re_o   (lane_re[l*W +: W]),
      .z_im_o   (lane_im[l*W +: W]),
      .z_bit_o  (lane_bit[l])
    );
  end

  // input alignment registers, loaded only on acceptance
  always_ff @(posedge clk) begin
    if (rst) begin
      y_re_q <= '0;
      y_im_q <= '0;
      r_re_q <= '0;
      r_im_q <= '0;
    end else if (start) begin
      y_re_q <= y_re_i;
      y_im_q <= y_im_i;
      r_re_q <= r_re_i;
      r_im_q <= r_im_i;
    end
  end

  // decision and soft registers, updated in place block by block
  always_ff @(posedge clk) begin
    if (rst) begin
      bits_q    <= '0;
      soft_re_q <= '0;
      soft_im_q <= '0;
    end else if (init) begin
      soft_re_q <= y_re_q;
      soft_im_q <= y_im_q;
      for (int k = 0; k < K; k++) bits_q[k] <= y_re_q[k*W + W - 1];
    end else if (sec) begin
      for (int k = 0; k < K; k++) begin
        if (blk == BW'(k / B)) begin
          bits_q[k]             <= lane_bit[k % B];
          soft_re_q[k*W +: W]   <= lane_re[(k % B)*W +: W];
          soft_im_q[k*W +: W]   <= lane_im[(k % B)*W +: W];
        end
      end
    end
  end

  assign in_ready_o = ready;
  assign bits_o     = bits_q;
  assign soft_re_o  = soft_re_q;
  assign soft_im_o  = soft_im_q;
endmodule

// File: rtl/bpdf_canceller_chk.sv
module bpdf_canceller_chk
  import bpdf_pkg::*;
#(
  parameter int K = 10,
  parameter int M = 4,
  parameter int W = 16,
  localparam int SW = safe_w(M + 1)
) (
  input logic           clk,
  input logic           rst,
  input logic           in_valid_i,
  input logic           in_ready_o,
  input logic [SW-1:0]  stage_sel_i,
  input logic           done_o,
  input logic [K-1:0]   bits_o,
  input logic [K*W-1:0] soft_re_o
);
  // R8: done is a single-cycle pulse
  a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R8: the engine is idle when it reports completion
  a_r8_ready_at_done: assert property (@(posedge clk) disable iff (rst)
    done_o |-> in_ready_o);

  // R9: an accepted vector makes the engine busy
  a_r9_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
    (in_valid_i && in_ready_o) |=> !in_ready_o);

  // R2, R8: stage 0 completes two edges after acceptance
  a_r2_sel0_latency: assert property (@(posedge clk) disable iff (rst)
    (in_valid_i && in_ready_o && (stage_sel_i == '0)) |=> ##1 done_o);

  // R8: results hold while idle and nothing is accepted
  a_r8_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (in_ready_o && !in_valid_i) |=> ($stable(bits_o) && $stable(soft_re_o)));
endmodule

bind bpdf_canceller bpdf_canceller_chk #(.K(K), .M(M), .W(W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .in_valid_i  (in_valid_i),
  .in_ready_o  (in_ready_o),
  .stage_sel_i (stage_sel_i),
  .done_o      (done_o),
  .bits_o      (bits_o),
  .soft_re_o   (soft_re_o)
);

// File: tb/bpdf_canceller_tb.sv
`timescale 1ns/1ps
module bpdf_canceller_tb;
  localparam int TK = 6;
  localparam int TM = 3;
  localparam int TW = 16;
  localparam int SW = bpdf_pkg::safe_w(TM + 1);
  localparam int ND = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [SW-1:0] sel_d = '0;
  logic [TK*TW-1:0] y_re_d = '0, y_im_d = '0;
  logic [TK*TK*TW-1:0] r_re_d = '0, r_im_d = '0;

  logic rdy [ND];
  logic dn [ND];
  logic [TK-1:0] bo [ND];
  logic [TK*TW-1:0] sre [ND];
  logic [TK*TW-1:0] sim [ND];

  int bsz [ND] = '{2, 1, TK};
  int yr [TK], yi [TK];
  int rr [TK][TK], ri [TK][TK];
  int ezr [ND][TK], ezi [ND][TK];
  bit eb [ND][TK];
  int tests = 0, fails = 0;
  int unsigned seed = 32'h1234_5678;

  always #4 clk = ~clk;

  bpdf_canceller #(.K(TK), .M(TM), .B(2), .W(TW)) u_dut (
    .clk(clk), .rst(rst), .in_valid_i(in_valid), .in_ready_o(rdy[0]),
    .stage_sel_i(sel_d), .y_re_i(y_re_d), .y_im_i(y_im_d),
    .r_re_i(r_re_d), .r_im_i(r_im_d), .done_o(dn[0]), .bits_o(bo[0]),
    .soft_re_o(sre[0]), .soft_im_o(sim[0]));

  bpdf_canceller #(.K(TK), .M(TM), .B(1), .W(TW)) u_dut_b1 (
    .clk(clk), .rst(rst), .in_valid_i(in_valid), .in_ready_o(rdy[1]),
    .stage_sel_i(sel_d), .y_re_i(y_re_d), .y_im_i(y_im_d),
    .r_re_i(r_re_d), .r_im_i(r_im_d), .done_o(dn[1]), .bits_o(bo[1]),
    .soft_re_o(sre[1]), .soft_im_o(sim[1]));

  bpdf_canceller #(.K(TK), .M(TM), .B(TK), .W(TW)) u_dut_bk (
    .clk(clk), .rst(rst), .in_valid_i(in_valid), .in_ready_o(rdy[2]),
    .stage_sel_i(sel_d), .y_re_i(y_re_d), .y_im_i(y_im_d),
    .r_re_i(r_re_d), .r_im_i(r_im_d), .done_o(dn[2]), .bits_o(bo[2]),
    .soft_re_o(sre[2]), .soft_im_o(sim[2]));

  task automatic chk(input bit ok, input string msg);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s", msg);
    end
  endtask

  function automatic int rnd(input int range);
    seed = seed * 32'd1664525 + 32'd1013904223;
    return int'((seed >> 8) % (2 * range + 1)) - range;
  endfunction

  function automatic int sat(input int x);
    return (x > 32767) ? 32767 : ((x < -32768) ? -32768 : x);
  endfunction

  // arithmetic model of the staged, block-ordered cancellation
  task automatic model(input int d, input int bs, input int sel);
    int zr [TK], zi [TK];
    bit dc [TK], nb [TK];
    int k, ar, ai;
    for (int u = 0; u < TK; u++) begin
      zr[u] = yr[u]; zi[u] = yi[u]; dc[u] = (yr[u] < 0); nb[u] = 1'b0;
    end
    for (int s = 1; s <= sel; s++) begin
      for (int b = 0; b < TK / bs; b++) begin
        for (int u = 0; u < bs; u++) begin
          k = b * bs + u;
          ar = yr[k]; ai = yi[k];
          for (int j = 0; j < TK; j++) begin
            if (j != k) begin
              if (dc[j]) begin ar += rr[k][j]; ai += ri[k][j]; end
              else begin ar -= rr[k][j]; ai -= ri[k][j]; end
            end
          end
          zr[k] = sat(ar); zi[k] = sat(ai); nb[k] = (zr[k] < 0);
        end
        for (int u = 0; u < bs; u++) dc[b * bs + u] = nb[b * bs + u];
      end
    end
    for (int u = 0; u < TK; u++) begin
      ezr[d][u] = zr[u]; ezi[d][u] = zi[u]; eb[d][u] = dc[u];
    end
  endtask

  task automatic make_vec(input int p);
    for (int k = 0; k < TK; k++) begin
      case (p)
        0: begin yr[k] = rnd(8000); yi[k] = rnd(8000); end
        1: begin yr[k] = rnd(4096); yi[k] = rnd(4096); end
        2: begin yr[k] = rnd(32767); yi[k] = rnd(32767); end
        default: begin yr[k] = (k % 2 == 0) ? 0 : rnd(4096); yi[k] = rnd(4096); end
      endcase
      for (int j = 0; j < TK; j++) begin
        case (p)
          0: begin rr[k][j] = 0; ri[k][j] = 0; end
          1: begin rr[k][j] = rnd(2048); ri[k][j] = rnd(2048); end
          2: begin rr[k][j] = rnd(32767); ri[k][j] = rnd(32767); end
          default: begin
            rr[k][j] = (k % 2 == 0) ? 0 : rnd(2048);
            ri[k][j] = (k % 2 == 0) ? 0 : rnd(2048);
          end
        endcase
      end
    end
  endtask

  task automatic drive_vec();
    for (int k = 0; k < TK; k++) begin
      y_re_d[k*TW +: TW] = yr[k][TW-1:0];
      y_im_d[k*TW +: TW] = yi[k][TW-1:0];
      for (int j = 0; j < TK; j++) begin
        r_re_d[(k*TK+j)*TW +: TW] = rr[k][j][TW-1:0];
        r_im_d[(k*TK+j)*TW +: TW] = ri[k][j][TW-1:0];
      end
    end
  endtask

  task automatic run(input int sel, input bit poke, input string ptag);
    int lat [ND];
    int n, a, e;
    bit all_done;
    for (int d = 0; d < ND; d++) begin
      model(d, bsz[d], sel);
      lat[d] = -1;
    end
    @(negedge clk);
    drive_vec();
    sel_d = SW'(sel);
    in_valid = 1'b1;
    @(posedge clk);
    #1;
    for (int d = 0; d < ND; d++)
      chk(rdy[d] == 1'b0, $sformatf("R9 dut%0d ready after accept actual=%0b expected=0", d, rdy[d]));
    if (poke) begin
      // junk offered while busy must be ignored
      y_re_d = ~y_re_d; r_re_d = ~r_re_d; r_im_d = ~r_im_d;
      sel_d = SW'(TM - sel);
      in_valid = 1'b1;
    end else begin
      in_valid = 1'b0;
    end
    n = 0;
    all_done = 1'b0;
    while (!all_done && n < 200) begin
      @(posedge clk);
      #1;
      n++;
      in_valid = 1'b0;
      all_done = 1'b1;
      for (int d = 0; d < ND; d++) begin
        if (dn[d] && lat[d] < 0) lat[d] = n;
        if (lat[d] < 0) all_done = 1'b0;
      end
    end
    for (int d = 0; d < ND; d++) begin
      e = 1 + 2 * sel * (TK / bsz[d]);
      chk(lat[d] == e, $sformatf("R8 dut%0d latency sel=%0d actual=%0d expected=%0d", d, sel, lat[d], e));
      for (int k = 0; k < TK; k++) begin
        chk(bo[d][k] == eb[d][k], $sformatf("%s dut%0d B=%0d sel=%0d user%0d bit actual=%0b expected=%0b",
            ptag, d, bsz[d], sel, k, bo[d][k], eb[d][k]));
        a = $signed(sre[d][k*TW +: TW]);
        chk(a == ezr[d][k], $sformatf("%s dut%0d B=%0d sel=%0d user%0d soft_re actual=%0d expected=%0d",
            ptag, d, bsz[d], sel, k, a, ezr[d][k]));
        a = $signed(sim[d][k*TW +: TW]);
        chk(a == ezi[d][k], $sformatf("%s dut%0d B=%0d sel=%0d user%0d soft_im actual=%0d expected=%0d",
            ptag, d, bsz[d], sel, k, a, ezi[d][k]));
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R8 watchdog actual=timeout expected=completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    string ptag;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    for (int d = 0; d < ND; d++) begin
      chk(rdy[d] == 1'b1, $sformatf("R1 dut%0d ready actual=%0b expected=1", d, rdy[d]));
      chk(dn[d] == 1'b0, $sformatf("R1 dut%0d done actual=%0b expected=0", d, dn[d]));
      chk(bo[d] == '0, $sformatf("R1 dut%0d bits actual=%0h expected=0", d, bo[d]));
      chk(sre[d] == '0 && sim[d] == '0, $sformatf("R1 dut%0d soft actual=%0h expected=0", d, sre[d]));
    end
    for (int v = 0; v < 40; v++) begin
      make_vec(v % 4);
      for (int s = 0; s <= TM; s++) begin
        case (v % 4)
          0: ptag = (s == 0) ? "R2" : "R3";
          1: ptag = (s == 0) ? "R2" : "R3,R4,R5";
          2: ptag = (s == 0) ? "R2,R6" : "R4,R5,R6";
          default: ptag = "R7,R3";
        endcase
        run(s, (v % 3) == 0, (v % 3 == 0) ? {ptag, ",R9"} : ptag);
      end
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule